// File: doc/BRIEF.md
# 32-bit Instruction Word Decoder with Immediate Builder

This block takes one 32-bit instruction word and, in a single combinational pass, classifies it by its major opcode and returns everything a later pipeline stage needs to start work on it. That means the register indices, the two function sub-fields, a format tag, a small set of control strobes, and an immediate value that has already been sign-extended to the machine word width. Words that are not full-width encodings, and opcodes outside the supported set, are reported through an illegal flag.

The major opcode is read as a two-dimensional table. Instruction bits 6:5 select the row and bits 4:2 select the column, and the whole lookup is qualified by bits 1:0 being 11. Control logic turns the table cell into a class, a format and strobes, and hands these to a separate field/immediate datapath as one packed struct. For stores, branches and jumps, the datapath reassembles the immediate from fields spread across the word.

The supported classes are loads, stores, conditional branches, jump-and-link, register jump-and-link, load-upper, add-upper-to-PC, register-register ALU, register-immediate ALU, and the four fused multiply-add opcodes.

Top module: `rvdec_top`

## Requirements
- R1: When bits 1:0 of the word are not 11, `illegal` is 1, `opClass` is 0, `fmt` is 0, `imm` is 0 and every strobe (`regWrite`, `memRead`, `memWrite`, `isBranch`, `isJal`, `isJalr`, `aluSrcImm`) is 0.
- R2: With bits 1:0 equal to 11, the class comes from row bits 6:5 and column bits 4:2. The cells and their `opClass` codes are: row 00 col 000 load=1, row 01 col 000 store=2, row 11 col 000 branch=3, row 11 col 011 jal=4, row 11 col 001 jalr=5, row 01 col 101 lui=6, row 00 col 101 auipc=7, row 01 col 100 register ALU=8, row 00 col 100 immediate ALU=9, row 10 cols 000..011 fused multiply-add=10. Every other cell gives `opClass` 0 and behaves as in R1.
- R3: `rdIdx`=bits 11:7, `funct3`=bits 14:12, `rs1Idx`=bits 19:15, `rs2Idx`=bits 24:20, `funct7`=bits 31:25 and `rs3Idx`=bits 31:27, extracted for every word, legal or not.
- R4: For load, immediate ALU and jalr, `imm` is bits 31:20 sign-extended; 0xFF018413 gives class 9, funct3 0, rd 8, rs1 3, imm −16.
- R5: For stores, `imm` is {bits 31:25, bits 11:7} sign-extended; 0xFEA11C23 gives class 2, funct3 001, rs2 10, rs1 2, imm −8.
- R6: For branches, `imm` is {b31, b7, b30:25, b11:8, 0} sign-extended from b31, so it is always even.
- R7: For jal, `imm` is {b31, b19:12, b20, b30:21, 0} sign-extended from b31, so it is always even.
- R8: For lui and auipc, `imm` is bits 31:12 placed in the upper bits with the low 12 bits zero.
- R9: For register ALU and fused multiply-add words, `imm` is 0.
- R10: `fmt` codes are: none=0, R=1, R4=2, I=3, S=4, B=5, U=6, J=7. Load, immediate ALU and jalr give I; store gives S; branch gives B; lui and auipc give U; jal gives J; register ALU gives R; fused multiply-add gives R4.
- R11: `regWrite` is 1 for every legal class except store and branch. `memRead` is 1 only for loads and `memWrite` is 1 only for stores.
- R12: `isBranch`, `isJal` and `isJalr` mark their own class only. `aluSrcImm` is 1 for load, store, immediate ALU, jalr, lui and auipc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| rdIdx | output | 5 | Destination register index |
| rs1Idx | output | 5 | First source register index |
| rs2Idx | output | 5 | Second source register index |
| rs3Idx | output | 5 | Third source register index (multiply-add) |
| funct3 | output | 3 | 3-bit function sub-field |
| funct7 | output | 7 | 7-bit function sub-field |
| fmt | output | 3 | Format tag (R10 codes) |
| opClass | output | 4 | Opcode class (R2 codes) |
| regWrite | output | 1 | Word writes a destination register |
| memRead | output | 1 | Word reads memory |
| memWrite | output | 1 | Word writes memory |
| isBranch | output | 1 | Conditional branch |
| isJal | output | 1 | PC-relative jump-and-link |
| isJalr | output | 1 | Register jump-and-link |
| aluSrcImm | output | 1 | Second ALU operand is the immediate |
| imm | output | XLEN | Sign-extended immediate |
| illegal | output | 1 | Not a 32-bit word or unsupported opcode |

## Verification
The bench builds the block with XLEN at its default of 32. At that width the sign bit of every immediate lands exactly on the top output bit, so a wrong extension width or a misplaced sign bit appears directly in the compared value. The random stream is biased toward the thirteen supported opcode values while keeping a share of unsupported cells and non-11 low bits. This exposes every table cell, the scattered S, B and J fields with random sign bits, and the gating on bits 1:0.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_R    = 3'd1,
    FMT_R4   = 3'd2,
    FMT_I    = 3'd3,
    FMT_S    = 3'd4,
    FMT_B    = 3'd5,
    FMT_U    = 3'd6,
    FMT_J    = 3'd7
  } fmt_e;

  typedef enum logic [3:0] {
    CLS_NONE   = 4'd0,
    CLS_LOAD   = 4'd1,
    CLS_STORE  = 4'd2,
    CLS_BRANCH = 4'd3,
    CLS_JAL    = 4'd4,
    CLS_JALR   = 4'd5,
    CLS_LUI    = 4'd6,
    CLS_AUIPC  = 4'd7,
    CLS_OP     = 4'd8,
    CLS_OPIMM  = 4'd9,
    CLS_FMA    = 4'd10
  } cls_e;

  typedef struct packed {
    fmt_e fmt;
    cls_e cls;
    logic regWrite;
    logic memRead;
    logic memWrite;
    logic isBranch;
    logic isJal;
    logic isJalr;
    logic aluSrcImm;
    logic illegal;
  } ctrl_t;

endpackage

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
(
  input  logic [6:0] opcodeBits,
  output ctrl_t      ctrl
);

  logic [1:0] rowSel;
  logic [2:0] colSel;
  logic       wideWord;
  cls_e       cellCls;

  assign rowSel   = opcodeBits[6:5];
  assign colSel   = opcodeBits[4:2];
  assign wideWord = (opcodeBits[1:0] == 2'b11);

  // two-dimensional opcode map: row picks the quadrant, column the cell
  always_comb begin
    cellCls = CLS_NONE;
    unique case (rowSel)
      2'b00: begin
        if (colSel == 3'b000)      cellCls = CLS_LOAD;
        else if (colSel == 3'b100) cellCls = CLS_OPIMM;
        else if (colSel == 3'b101) cellCls = CLS_AUIPC;
      end
      2'b01: begin
        if (colSel == 3'b000)      cellCls = CLS_STORE;
        else if (colSel == 3'b100) cellCls = CLS_OP;
        else if (colSel == 3'b101) cellCls = CLS_LUI;
      end
      2'b10: begin
        if (colSel[2] == 1'b0)     cellCls = CLS_FMA;
      end
      2'b11: begin
        if (colSel == 3'b000)      cellCls = CLS_BRANCH;
        else if (colSel == 3'b001) cellCls = CLS_JALR;
        else if (colSel == 3'b011) cellCls = CLS_JAL;
      end
      default: cellCls = CLS_NONE;
    endcase
  end

  always_comb begin
    ctrl = '0;
    ctrl.cls = wideWord ? cellCls : CLS_NONE;
    ctrl.illegal = (ctrl.cls == CLS_NONE);
    unique case (ctrl.cls)
      CLS_LOAD:   begin ctrl.fmt = FMT_I;  ctrl.regWrite = 1'b1; ctrl.memRead = 1'b1;  ctrl.aluSrcImm = 1'b1; end
      CLS_STORE:  begin ctrl.fmt = FMT_S;  ctrl.memWrite = 1'b1; ctrl.aluSrcImm = 1'b1; end
      CLS_BRANCH: begin ctrl.fmt = FMT_B;  ctrl.isBranch = 1'b1; end
      CLS_JAL:    begin ctrl.fmt = FMT_J;  ctrl.regWrite = 1'b1; ctrl.isJal = 1'b1; end
      CLS_JALR:   begin ctrl.fmt = FMT_I;  ctrl.regWrite = 1'b1; ctrl.isJalr = 1'b1; ctrl.aluSrcImm = 1'b1; end
      CLS_LUI:    begin ctrl.fmt = FMT_U;  ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; end
      CLS_AUIPC:  begin ctrl.fmt = FMT_U;  ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; end
      CLS_OP:     begin ctrl.fmt = FMT_R;  ctrl.regWrite = 1'b1; end
      CLS_OPIMM:  begin ctrl.fmt = FMT_I;  ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; end
      CLS_FMA:    begin ctrl.fmt = FMT_R4; ctrl.regWrite = 1'b1; end
      default:    ctrl.fmt = FMT_NONE;
    endcase
  end

  always_comb begin
    // R1: a word with low bits other than 11 must never drive a strobe
    a_r1_narrow_quiet: assert (wideWord || (!ctrl.regWrite && !ctrl.memRead && !ctrl.memWrite
                                            && !ctrl.isBranch && !ctrl.isJal && !ctrl.isJalr
                                            && !ctrl.aluSrcImm));
    a_r10_illegal_no_fmt: assert (ctrl.illegal == (ctrl.fmt == FMT_NONE));
    a_r11_mem_exclusive: assert (!(ctrl.memRead && ctrl.memWrite));
    a_r11_no_wb_s_b: assert (!((ctrl.fmt == FMT_S || ctrl.fmt == FMT_B) && ctrl.regWrite));
    a_r12_flow_onehot: assert ($onehot0({ctrl.isBranch, ctrl.isJal, ctrl.isJalr, ctrl.memRead, ctrl.memWrite}));
  end

endmodule

// File: rtl/rvdec_dpath.sv
module rvdec_dpath
  import rvdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:7] instrHi,
  input  ctrl_t              ctrl,
  output logic [REG_W-1:0]   rdIdx,
  output logic [REG_W-1:0]   rs1Idx,
  output logic [REG_W-1:0]   rs2Idx,
  output logic [REG_W-1:0]   rs3Idx,
  output logic [2:0]         funct3,
  output logic [6:0]         funct7,
  output logic [XLEN-1:0]    imm
);

  logic signed [INSTR_W-1:0] immRaw;

  assign rdIdx  = instrHi[11:7];
  assign funct3 = instrHi[14:12];
  assign rs1Idx = instrHi[19:15];
  assign rs2Idx = instrHi[24:20];
  assign funct7 = instrHi[31:25];
  assign rs3Idx = instrHi[31:27];

  always_comb begin
    unique case (ctrl.fmt)
      FMT_I: immRaw = {{20{instrHi[31]}}, instrHi[31:20]};
      FMT_S: immRaw = {{20{instrHi[31]}}, instrHi[31:25], instrHi[11:7]};
      FMT_B: immRaw = {{19{instrHi[31]}}, instrHi[31], instrHi[7], instrHi[30:25], instrHi[11:8], 1'b0};
      FMT_J: immRaw = {{11{instrHi[31]}}, instrHi[31], instrHi[19:12], instrHi[20], instrHi[30:21], 1'b0};
      FMT_U: immRaw = {instrHi[31:12], 12'h000};
      default: immRaw = '0;
    endcase
  end

  assign imm = XLEN'(immRaw);

  always_comb begin
    a_r6_r7_even_offset: assert (!(ctrl.fmt == FMT_B || ctrl.fmt == FMT_J) || imm[0] == 1'b0);
    a_r8_upper_low_zero: assert (ctrl.fmt != FMT_U || imm[11:0] == 12'h000);
    a_r9_no_imm_reg: assert (!(ctrl.fmt == FMT_R || ctrl.fmt == FMT_R4 || ctrl.fmt == FMT_NONE) || imm == '0);
    a_r4_sign_top: assert (!(ctrl.fmt == FMT_I || ctrl.fmt == FMT_S || ctrl.fmt == FMT_B
                             || ctrl.fmt == FMT_J || ctrl.fmt == FMT_U)
                           || imm[XLEN-1] == instrHi[31]);
  end

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
  import rvdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instrWord,
  output logic [4:0]      rdIdx,
  output logic [4:0]      rs1Idx,
  output logic [4:0]      rs2Idx,
  output logic [4:0]      rs3Idx,
  output logic [2:0]      funct3,
  output logic [6:0]      funct7,
  output logic [2:0]      fmt,
  output logic [3:0]      opClass,
  output logic            regWrite,
  output logic            memRead,
  output logic            memWrite,
  output logic            isBranch,
  output logic            isJal,
  output logic            isJalr,
  output logic            aluSrcImm,
  output logic [XLEN-1:0] imm,
  output logic            illegal
);

  ctrl_t ctrlBus;

  rvdec_ctrl u_ctrl (
    .opcodeBits (instrWord[6:0]),
    .ctrl       (ctrlBus)
  );

  rvdec_dpath #(.XLEN(XLEN)) u_dpath (
    .instrHi (instrWord[31:7]),
    .ctrl    (ctrlBus),
    .rdIdx   (rdIdx),
    .rs1Idx  (rs1Idx),
    .rs2Idx  (rs2Idx),
    .rs3Idx  (rs3Idx),
    .funct3  (funct3),
    .funct7  (funct7),
    .imm     (imm)
  );

  assign fmt       = ctrlBus.fmt;
  assign opClass   = ctrlBus.cls;
  assign regWrite  = ctrlBus.regWrite;
  assign memRead   = ctrlBus.memRead;
  assign memWrite  = ctrlBus.memWrite;
  assign isBranch  = ctrlBus.isBranch;
  assign isJal     = ctrlBus.isJal;
  assign isJalr    = ctrlBus.isJalr;
  assign aluSrcImm = ctrlBus.aluSrcImm;
  assign illegal   = ctrlBus.illegal;

endmodule

// File: tb/rvdec_top_tb.sv
module rvdec_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instrWord;
  logic [4:0]  rdIdx, rs1Idx, rs2Idx, rs3Idx;
  logic [2:0]  funct3, fmt;
  logic [6:0]  funct7;
  logic [3:0]  opClass;
  logic        regWrite, memRead, memWrite, isBranch, isJal, isJalr, aluSrcImm, illegal;
  logic [31:0] imm;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  rvdec_top u_dut (
    .instrWord(instrWord), .rdIdx(rdIdx), .rs1Idx(rs1Idx), .rs2Idx(rs2Idx), .rs3Idx(rs3Idx),
    .funct3(funct3), .funct7(funct7), .fmt(fmt), .opClass(opClass), .regWrite(regWrite),
    .memRead(memRead), .memWrite(memWrite), .isBranch(isBranch), .isJal(isJal), .isJalr(isJalr),
    .aluSrcImm(aluSrcImm), .imm(imm), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input logic [31:0] w);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s word=%08h actual=%0h expected=%0h", tag, w, act, exp);
    end
  endtask

  // class code from the full 7-bit opcode (R2)
  function automatic int refClass(input logic [31:0] w);
    case (w[6:0])
      7'h03: return 1;  7'h23: return 2;  7'h63: return 3;
      7'h6F: return 4;  7'h67: return 5;  7'h37: return 6;
      7'h17: return 7;  7'h33: return 8;  7'h13: return 9;
      7'h43, 7'h47, 7'h4B, 7'h4F: return 10;
      default: return 0;
    endcase
  endfunction

  // format code per class (R10)
  function automatic int refFmt(input int c);
    case (c)
      1, 5, 9: return 3;
      2: return 4;
      3: return 5;
      6, 7: return 6;
      4: return 7;
      8: return 1;
      10: return 2;
      default: return 0;
    endcase
  endfunction

  // strobes packed as {regWrite,memRead,memWrite,isBranch,isJal,isJalr,aluSrcImm} (R11, R12)
  function automatic logic [6:0] refStrobes(input int c);
    logic [6:0] s;
    s = '0;
    if (c != 0 && c != 2 && c != 3) s[6] = 1'b1;
    s[5] = (c == 1);
    s[4] = (c == 2);
    s[3] = (c == 3);
    s[2] = (c == 4);
    s[1] = (c == 5);
    s[0] = (c == 1 || c == 2 || c == 9 || c == 5 || c == 6 || c == 7);
    return s;
  endfunction

  function automatic logic [31:0] refImm(input logic [31:0] w, input int f);
    int v;
    logic [11:0] f12;
    logic [19:0] f20;
    case (f)
      3: begin f12 = w[31:20]; v = int'($signed(f12)); end
      4: begin f12 = {w[31:25], w[11:7]}; v = int'($signed(f12)); end
      5: begin f12 = {w[31], w[7], w[30:25], w[11:8]}; v = int'($signed(f12)) * 2; end
      7: begin f20 = {w[31], w[19:12], w[20], w[30:21]}; v = int'($signed(f20)) * 2; end
      6: v = int'(w[31:12]) << 12;
      default: v = 0;
    endcase
    return 32'(v);
  endfunction

  function automatic string immTag(input int f);
    case (f)
      3: return "R4";
      4: return "R5";
      5: return "R6";
      7: return "R7";
      6: return "R8";
      1, 2: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic apply(input logic [31:0] w);
    int c;
    int f;
    @(negedge clk);
    instrWord = w;
    #1;
    c = refClass(w);
    if (w[1:0] != 2'b11) c = 0;
    f = refFmt(c);
    chk("R2", 32'(opClass), 32'(c), w);
    chk("R1", 32'(illegal), 32'(c == 0), w);
    chk("R10", 32'(fmt), 32'(f), w);
    chk("R3", {rdIdx, funct3, rs1Idx, rs2Idx, funct7, 2'b00}, {w[11:7], w[14:12], w[19:15], w[24:20], w[31:25], 2'b00}, w);
    chk("R3", 32'(rs3Idx), 32'(w[31:27]), w);
    chk("R11", {29'd0, regWrite, memRead, memWrite}, {29'd0, refStrobes(c)[6:4]}, w);
    chk("R12", {28'd0, isBranch, isJal, isJalr, aluSrcImm}, {28'd0, refStrobes(c)[3:0]}, w);
    chk(immTag(f), imm, refImm(w, f), w);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] ops [13];
    logic [31:0] w;
    ops = '{7'h03, 7'h23, 7'h63, 7'h6F, 7'h67, 7'h37, 7'h17, 7'h33, 7'h13, 7'h43, 7'h47, 7'h4B, 7'h4F};
    instrWord = 32'h0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // reset-time state: all-zero word has low bits 00 (R1)
    chk("R1", 32'(illegal), 32'd1, instrWord);
    chk("R1", {25'd0, regWrite, memRead, memWrite, isBranch, isJal, isJalr, aluSrcImm}, 32'd0, instrWord);
    rstN = 1'b1;

    // directed corner cases
    apply(32'hFEA11C23);            // R5: halfword store, rs2 10, rs1 2, offset -8
    chk("R5", imm, 32'hFFFF_FFF8, 32'hFEA11C23);
    chk("R5", {27'd0, rs2Idx}, 32'd10, 32'hFEA11C23);
    apply(32'hFF018413);            // R4: addi, rd 8, rs1 3, imm -16
    chk("R4", imm, 32'hFFFF_FFF0, 32'hFF018413);
    chk("R4", {27'd0, rdIdx}, 32'd8, 32'hFF018413);
    apply(32'hFF018412);            // R1: low bits 10
    apply(32'hFF018411);            // R1: low bits 01
    apply(32'h0000000F);            // R2: unsupported cell row 00 col 011
    apply(32'h0000007F);            // R2: unsupported cell row 11 col 111
    apply(32'h0000005B);            // R2: row 10 col 110 is outside the multiply-add group
    apply(32'h123450B7);            // R8: lui
    chk("R8", imm, 32'h1234_5000, 32'h123450B7);
    apply(32'hFFFFF0EF);            // R7: jal -2
    chk("R7", imm, 32'hFFFF_FFFE, 32'hFFFFF0EF);
    apply(32'h80000063);            // R6: branch most negative offset
    chk("R6", imm, 32'hFFFF_F000, 32'h80000063);
    apply(32'h7E000FE3);            // R6: branch largest positive
    chk("R6", imm, 32'h0000_0FFE, 32'h7E000FE3);
    apply(32'hFFFFFFC3);            // R9: multiply-add form, imm zero, rs3 31
    apply(32'hFFFFFFB3);            // R9: register ALU

    // random words, biased toward supported opcodes
    for (int i = 0; i < 4000; i++) begin
      w = $urandom;
      if (($urandom % 4) != 0) w[6:0] = ops[$urandom % 13];
      else if (($urandom % 2) != 0) w[1:0] = 2'b11;
      apply(w);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule